// File: doc/BRIEF.md
# Masked Stream Identifier Match Table

This block sits at the front of an I/O translation unit. It sorts every stream identifier that a bus master presents into a translation context. It holds a small table of programmable entries. Each entry carries a stored identifier, a don't-care mask, a valid bit and a context index. A stored mask bit set to one makes the comparison ignore that identifier bit. One entry can therefore cover a whole aligned group of identifiers, so a table with fewer entries than the masters have distinct identifiers can still serve all of them.

Software fills the table through a single-cycle write port and may rewrite any entry while traffic is running. A lookup strobe with an identifier produces a registered response on the next cycle. The response holds a hit flag, the index of the entry that matched, that entry's context index, an alias flag and a fault flag. When two or more valid entries cover the same identifier, the block does not pick one silently. It reports the lowest-numbered entry and raises the alias flag.

Top module: `sid_match_table`

## Requirements
- R1: An entry matches an identifier when every identifier bit whose mask bit is 0 equals the stored bit. Bits whose mask bit is 1 are ignored, including the upper bits (mask 0x7000 with stored 0x0040 matches 0x1040 and 0x7040).
- R2: An entry with stored value 0x020 and mask 0x00F matches every identifier from 0x020 through 0x02F, and matches neither 0x01F nor 0x030.
- R3: An entry with mask 0 matches only the single identifier equal to its stored value.
- R4: On a hit, `rsp_ctx` carries the context index written with the matched entry, and `rsp_idx` carries that entry's number.
- R5: When more than one valid entry matches, `rsp_idx` and `rsp_ctx` come from the lowest-numbered matching entry and `rsp_alias` is 1. With exactly one match, `rsp_alias` is 0.
- R6: A lookup that matches no valid entry gives `rsp_hit`=0, `rsp_fault`=1, `rsp_alias`=0, and `rsp_idx` and `rsp_ctx` both 0.
- R7: Reset clears every entry to invalid, and invalid entries never match. A lookup right after reset faults, and all response outputs are 0 during reset.
- R8: A lookup strobed at one clock edge is answered with `rsp_valid`=1 after that edge. In a cycle with no strobe, `rsp_valid`, `rsp_hit`, `rsp_fault` and `rsp_alias` are all 0.
- R9: A lookup in the same cycle as a table write uses the table contents from before the write. The written entry takes effect from the next lookup on.
- R10: A write with `wr_idx` at or above the entry count changes no entry.
- R11: Rewriting an entry with `wr_valid`=0 removes it from matching from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | IDX_W | Entry number to write |
| wr_valid | input | 1 | Valid bit written into the entry |
| wr_value | input | ID_W | Stored identifier |
| wr_mask | input | ID_W | Don't-care mask, 1 means ignore the bit |
| wr_ctx | input | CTX_W | Context index for the entry |
| lk_valid | input | 1 | Lookup strobe |
| lk_id | input | ID_W | Identifier to classify |
| rsp_valid | output | 1 | Response present (one cycle after the strobe) |
| rsp_hit | output | 1 | At least one valid entry matched |
| rsp_idx | output | IDX_W | Lowest matching entry number |
| rsp_ctx | output | CTX_W | Context index of that entry |
| rsp_alias | output | 1 | Two or more entries matched |
| rsp_fault | output | 1 | No entry matched |

## Verification
The bench builds the block with its default parameters: 40 entries, 15-bit identifiers and 7-bit context indices. It can therefore write the top entry (39), use all-ones identifiers across the full width, and attempt a write at an index between 40 and 63, which the 6-bit index port can express but the table does not hold. Because the table is full width, a mask over the upper identifier bits can be shown to fold widely separated identifiers onto one entry. A multi-entry overlap checks that the lowest entry wins while the alias flag is raised.

// File: rtl/sid_match_pkg.sv
package sid_match_pkg;

    localparam int unsigned DEF_ENTRIES = 40;
    localparam int unsigned DEF_ID_W    = 15;
    localparam int unsigned DEF_CTX_W   = 7;

    // Index width for a table of n entries, never below one bit.
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sid_entry_bank.sv
module sid_entry_bank #(
    parameter int unsigned NUM_ENTRIES = 40,
    parameter int unsigned ID_W        = 15,
    parameter int unsigned CTX_W       = 7,
    parameter int unsigned IDX_W       = 6
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [IDX_W-1:0]                    wr_idx,
    input  logic                                wr_valid,
    input  logic [ID_W-1:0]                     wr_value,
    input  logic [ID_W-1:0]                     wr_mask,
    input  logic [CTX_W-1:0]                    wr_ctx,
    output logic [NUM_ENTRIES-1:0]              ent_vld,
    output logic [NUM_ENTRIES-1:0][ID_W-1:0]    ent_val,
    output logic [NUM_ENTRIES-1:0][ID_W-1:0]    ent_msk,
    output logic [NUM_ENTRIES-1:0][CTX_W-1:0]   ent_ctx
);

    typedef struct packed {
        logic              vld;
        logic [ID_W-1:0]   val;
        logic [ID_W-1:0]   msk;
        logic [CTX_W-1:0]  ctx;
    } entry_t;

    entry_t tbl_d [NUM_ENTRIES];
    entry_t tbl_q [NUM_ENTRIES];

    always_comb begin
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            tbl_d[i] = tbl_q[i];
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                tbl_d[i].vld = wr_valid;
                tbl_d[i].val = wr_value;
                tbl_d[i].msk = wr_mask;
                tbl_d[i].ctx = wr_ctx;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (!rst_n) begin
                tbl_q[i] <= '0;
            end else begin
                tbl_q[i] <= tbl_d[i];
            end
        end
    end

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_out
        assign ent_vld[g] = tbl_q[g].vld;
        assign ent_val[g] = tbl_q[g].val;
        assign ent_msk[g] = tbl_q[g].msk;
        assign ent_ctx[g] = tbl_q[g].ctx;
    end

endmodule

// File: rtl/sid_cmp_array.sv
module sid_cmp_array #(
    parameter int unsigned NUM_ENTRIES = 40,
    parameter int unsigned ID_W        = 15
) (
    input  logic [ID_W-1:0]                   lk_id,
    input  logic [NUM_ENTRIES-1:0]            ent_vld,
    input  logic [NUM_ENTRIES-1:0][ID_W-1:0]  ent_val,
    input  logic [NUM_ENTRIES-1:0][ID_W-1:0]  ent_msk,
    output logic [NUM_ENTRIES-1:0]            hit_vec
);

    // One ternary comparator per entry: care bits must agree.
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        logic [ID_W-1:0] diff;
        assign diff       = (lk_id ^ ent_val[g]) & ~ent_msk[g];
        assign hit_vec[g] = ent_vld[g] & (diff == '0);
    end

endmodule

// File: rtl/sid_prio_enc.sv
module sid_prio_enc #(
    parameter int unsigned NUM_ENTRIES = 40,
    parameter int unsigned IDX_W       = 6
) (
    input  logic [NUM_ENTRIES-1:0] hit_vec,
    output logic                   any_hit,
    output logic                   multi_hit,
    output logic [IDX_W-1:0]       first_idx
);

    logic [NUM_ENTRIES-1:0] rest;

    always_comb begin
        first_idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                first_idx = IDX_W'(i);
            end
        end
    end

    // Clearing the lowest set bit leaves something only if two or more hit.
    assign rest      = hit_vec & (hit_vec - NUM_ENTRIES'(1));
    assign any_hit   = |hit_vec;
    assign multi_hit = |rest;

endmodule

// File: rtl/sid_match_table.sv
module sid_match_table #(
    parameter int unsigned NUM_ENTRIES = sid_match_pkg::DEF_ENTRIES,
    parameter int unsigned ID_W        = sid_match_pkg::DEF_ID_W,
    parameter int unsigned CTX_W       = sid_match_pkg::DEF_CTX_W,
    localparam int unsigned IDX_W      = sid_match_pkg::idx_bits(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic [ID_W-1:0]   wr_value,
    input  logic [ID_W-1:0]   wr_mask,
    input  logic [CTX_W-1:0]  wr_ctx,
    input  logic              lk_valid,
    input  logic [ID_W-1:0]   lk_id,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_idx,
    output logic [CTX_W-1:0]  rsp_ctx,
    output logic              rsp_alias,
    output logic              rsp_fault
);

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [IDX_W-1:0]  idx;
        logic [CTX_W-1:0]  ctx;
        logic              alias_f;
        logic              fault;
    } rsp_t;

    logic [NUM_ENTRIES-1:0]              ent_vld;
    logic [NUM_ENTRIES-1:0][ID_W-1:0]    ent_val;
    logic [NUM_ENTRIES-1:0][ID_W-1:0]    ent_msk;
    logic [NUM_ENTRIES-1:0][CTX_W-1:0]   ent_ctx;
    logic [NUM_ENTRIES-1:0]              hit_vec;
    logic                                any_hit;
    logic                                multi_hit;
    logic [IDX_W-1:0]                    first_idx;

    rsp_t rsp_d;
    rsp_t rsp_q;

    sid_entry_bank #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .ID_W        (ID_W),
        .CTX_W       (CTX_W),
        .IDX_W       (IDX_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_valid (wr_valid),
        .wr_value (wr_value),
        .wr_mask  (wr_mask),
        .wr_ctx   (wr_ctx),
        .ent_vld  (ent_vld),
        .ent_val  (ent_val),
        .ent_msk  (ent_msk),
        .ent_ctx  (ent_ctx)
    );

    sid_cmp_array #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .ID_W        (ID_W)
    ) u_cmp (
        .lk_id   (lk_id),
        .ent_vld (ent_vld),
        .ent_val (ent_val),
        .ent_msk (ent_msk),
        .hit_vec (hit_vec)
    );

    sid_prio_enc #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .IDX_W       (IDX_W)
    ) u_prio (
        .hit_vec   (hit_vec),
        .any_hit   (any_hit),
        .multi_hit (multi_hit),
        .first_idx (first_idx)
    );

    // Lookups read the registered table, so a write in the same cycle
    // only becomes visible to the next lookup.
    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = lk_valid;
        if (lk_valid) begin
            rsp_d.hit     = any_hit;
            rsp_d.fault   = ~any_hit;
            rsp_d.alias_f = multi_hit;
            if (any_hit) begin
                rsp_d.idx = first_idx;
                rsp_d.ctx = ent_ctx[first_idx];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_idx   = rsp_q.idx;
    assign rsp_ctx   = rsp_q.ctx;
    assign rsp_alias = rsp_q.alias_f;
    assign rsp_fault = rsp_q.fault;

endmodule

// File: rtl/sid_match_chk.sv
module sid_match_chk #(
    parameter int unsigned NUM_ENTRIES = 40,
    parameter int unsigned IDX_W       = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [IDX_W-1:0]  rsp_idx,
    input logic              rsp_alias,
    input logic              rsp_fault
);

    AST_RSP_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid); // R8

    AST_NO_RSP_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_fault && !rsp_alias)); // R8

    AST_HIT_OR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != rsp_fault)); // R6

    AST_ALIAS_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_alias |-> rsp_hit); // R5

    AST_IDX_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> ({1'b0, rsp_idx} < (IDX_W + 1)'(NUM_ENTRIES))); // R4

    AST_MISS_ZERO_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_idx == '0)); // R6

endmodule

bind sid_match_table sid_match_chk #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .IDX_W       (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_idx   (rsp_idx),
    .rsp_alias (rsp_alias),
    .rsp_fault (rsp_fault)
);

// File: tb/tb_sid_match_table.sv
module tb_sid_match_table;

    localparam int unsigned N     = 40;
    localparam int unsigned IDW   = 15;
    localparam int unsigned CTXW  = 7;
    localparam int unsigned IDXW  = 6;
    localparam int unsigned NVEC  = 13;

    typedef struct packed {
        logic [IDW-1:0]  id;
        logic            hit;
        logic [IDXW-1:0] idx;
        logic [CTXW-1:0] ctx;
        logic            alias_f;
    } vec_t;

    // Expected results against the table programmed below.
    localparam vec_t VECS [NVEC] = '{
        '{15'h0020, 1'b1, 6'd0,  7'd5,   1'b0},  // R2 low edge
        '{15'h002F, 1'b1, 6'd0,  7'd5,   1'b0},  // R2 high edge
        '{15'h0027, 1'b1, 6'd0,  7'd5,   1'b0},  // R2 inside
        '{15'h001F, 1'b0, 6'd0,  7'd0,   1'b0},  // R2 below
        '{15'h0030, 1'b0, 6'd0,  7'd0,   1'b0},  // R2 above
        '{15'h0100, 1'b1, 6'd3,  7'd9,   1'b1},  // R5 overlap
        '{15'h0104, 1'b1, 6'd5,  7'd11,  1'b0},  // R4 single
        '{15'h0101, 1'b0, 6'd0,  7'd0,   1'b0},  // R3 exact only
        '{15'h7FFF, 1'b1, 6'd39, 7'd127, 1'b0},  // R3 top entry
        '{15'h7FFE, 1'b0, 6'd0,  7'd0,   1'b0},  // R3 neighbour
        '{15'h1040, 1'b1, 6'd7,  7'd3,   1'b0},  // R1 upper ignored
        '{15'h7040, 1'b1, 6'd7,  7'd3,   1'b0},  // R1 upper ignored
        '{15'h0041, 1'b0, 6'd0,  7'd0,   1'b0}   // R1 care bit
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [IDXW-1:0]  wr_idx = '0;
    logic             wr_valid = 1'b0;
    logic [IDW-1:0]   wr_value = '0;
    logic [IDW-1:0]   wr_mask = '0;
    logic [CTXW-1:0]  wr_ctx = '0;
    logic             lk_valid = 1'b0;
    logic [IDW-1:0]   lk_id = '0;
    logic             rsp_valid;
    logic             rsp_hit;
    logic [IDXW-1:0]  rsp_idx;
    logic [CTXW-1:0]  rsp_ctx;
    logic             rsp_alias;
    logic             rsp_fault;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sid_match_table dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_valid  (wr_valid),
        .wr_value  (wr_value),
        .wr_mask   (wr_mask),
        .wr_ctx    (wr_ctx),
        .lk_valid  (lk_valid),
        .lk_id     (lk_id),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_idx   (rsp_idx),
        .rsp_ctx   (rsp_ctx),
        .rsp_alias (rsp_alias),
        .rsp_fault (rsp_fault)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_entry(input logic [IDXW-1:0] idx, input logic vld,
                               input logic [IDW-1:0] val, input logic [IDW-1:0] msk,
                               input logic [CTXW-1:0] ctx);
        wr_en = 1'b1; wr_idx = idx; wr_valid = vld;
        wr_value = val; wr_mask = msk; wr_ctx = ctx;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Strobe at a falling edge; the response is registered at the next
    // rising edge and sampled at the falling edge after it.
    task automatic lookup(input logic [IDW-1:0] id);
        lk_valid = 1'b1; lk_id = id;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string req, input logic hit, input logic [IDXW-1:0] idx,
                              input logic [CTXW-1:0] ctx, input logic al);
        logic [IDXW+CTXW+3:0] act;
        logic [IDXW+CTXW+3:0] exp;
        act = {rsp_valid, rsp_hit, rsp_fault, rsp_alias, rsp_idx, rsp_ctx};
        exp = {1'b1, hit, ~hit, al, idx, ctx};
        check(req, 32'(act), 32'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R7: outputs quiet in reset
        check("R7 reset outputs", 32'({rsp_valid, rsp_hit, rsp_fault, rsp_alias, rsp_idx, rsp_ctx}), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: table empty after reset
        lookup(15'h0020);
        expect_rsp("R7 empty table faults", 1'b0, '0, '0, 1'b0);
        @(negedge clk);
        // R8: no strobe, quiet outputs
        check("R8 idle quiet", 32'({rsp_valid, rsp_hit, rsp_fault, rsp_alias}), 32'h0);

        write_entry(6'd0,  1'b1, 15'h0020, 15'h000F, 7'd5);
        write_entry(6'd3,  1'b1, 15'h0100, 15'h0000, 7'd9);
        write_entry(6'd5,  1'b1, 15'h0104, 15'h0004, 7'd11);
        write_entry(6'd7,  1'b1, 15'h0040, 15'h7000, 7'd3);
        write_entry(6'd39, 1'b1, 15'h7FFF, 15'h0000, 7'd127);

        for (int v = 0; v < NVEC; v++) begin
            lookup(VECS[v].id);
            expect_rsp($sformatf("R1-vector %0d", v), VECS[v].hit, VECS[v].idx,
                       VECS[v].ctx, VECS[v].alias_f);
        end

        // R9: write and lookup in the same cycle
        wr_en = 1'b1; wr_idx = 6'd10; wr_valid = 1'b1;
        wr_value = 15'h0200; wr_mask = '0; wr_ctx = 7'd20;
        lk_valid = 1'b1; lk_id = 15'h0200;
        @(negedge clk);
        wr_en = 1'b0; lk_valid = 1'b0;
        expect_rsp("R9 same-cycle write unseen", 1'b0, '0, '0, 1'b0);
        lookup(15'h0200);
        expect_rsp("R9 write seen next cycle", 1'b1, 6'd10, 7'd20, 1'b0);

        // R11: invalidate entry
        write_entry(6'd10, 1'b0, 15'h0200, 15'h0000, 7'd20);
        lookup(15'h0200);
        expect_rsp("R11 invalidated entry", 1'b0, '0, '0, 1'b0);

        // R10: out-of-range index writes nothing
        write_entry(6'd45, 1'b1, 15'h0300, 15'h0000, 7'd44);
        lookup(15'h0300);
        expect_rsp("R10 out-of-range write", 1'b0, '0, '0, 1'b0);

        // R5: remove the lower overlap, alias clears, upper entry wins
        write_entry(6'd3, 1'b0, 15'h0100, 15'h0000, 7'd9);
        lookup(15'h0100);
        expect_rsp("R5 single after removal", 1'b1, 6'd5, 7'd11, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule